// File: doc/BRIEF.md
# MMIO-to-Legacy Register Window Bridge

This block is a memory-mapped slave that exposes a 4 KiB register window and translates each access into an ordered series of narrow operations on two legacy back ends. The first back end is a byte-wide port bus that carries classic display-controller registers. The second is an index/data pair in front of an extended display register file.

A requester presents address, size (1 to 4 bytes), direction and write data with `bus_req` while `bus_ready` is high. The bridge captures the access on that clock edge and drops `bus_ready`. It then issues one back-end operation per clock, at ascending addresses and low byte first, and raises `bus_ready` again once the last operation has been issued. Read data is assembled little-endian and held on `bus_rdata` until the next access is captured.

Because bytes go out low byte first, a single halfword write to an index/data port pair sets the index before the data. On the extended side, each halfword slot maps straight to one indexed register: the bridge writes the slot number to the index register and then moves the data.

Top module: `mmio_legacy_bridge`

## Requirements
- R1: After reset, `bus_ready` is 1, `bus_rdata` is 0, and neither `lp_valid` nor `ex_valid` is asserted.
- R2: An access is captured on an edge where `bus_req` and `bus_ready` are both 1. `bus_ready` then stays 0 for exactly max(N,1) cycles, where N is the number of steps, with at most one back-end operation per cycle and none while `bus_ready` is 1. `bus_rdata` is valid when `bus_ready` returns. It reads 0 for writes and for accesses that issue no operations.
- R3: Window offsets 0x400 to 0x41F form the port region. Offset 0x400+k maps to port address 0x3C0+k on `lp_addr`.
- R4: A port-region access of S bytes is issued as S byte operations at port, port+1, and so on up to port+S-1, in that order. Byte k of the access is carried on `bus_wdata[8k+7:8k]` or returned on `bus_rdata[8k+7:8k]`. A halfword write to an index/data port pair therefore updates the index before the data.
- R5: A byte of a port-region access whose offset is 0x420 or above is not issued on the port bus. It still takes its cycle and reads as 0.
- R6: Window offsets 0x500 to 0x515 form the extended region of 11 halfword slots. Halfword h of an access uses slot ((offset-0x500)>>1)+h. Each halfword takes two cycles. The first is an index write (`ex_sel`=0, `ex_we`=1, `ex_wdata`=slot). The second is a data operation (`ex_sel`=1) carrying `bus_wdata[16h+15:16h]` or returning it in `bus_rdata[16h+15:16h]`. The step count is S rounded up to even.
- R7: A 1-byte extended-region access is handled as a full halfword operation on the slot that contains it, ignoring address bit 0, and returns the whole 16-bit value.
- R8: Extended-region slots numbered 11 or higher issue neither an index nor a data operation. Their cycles still elapse and they read as 0.
- R9: An offset outside both regions issues no operation. It completes after one cycle, and a read returns 0.
- R10: When `win_en` is 0 at capture, the access issues no operation, completes after one cycle, and returns 0.
- R11: A size of 0 or above 4 issues no operation, completes after one cycle, and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Window enable, sampled at capture |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Assembled read data |
| bus_ready | output | 1 | High when idle; low while an access is in progress |
| lp_valid | output | 1 | Port-bus operation this cycle |
| lp_we | output | 1 | Port-bus write |
| lp_addr | output | 10 | Port address |
| lp_wdata | output | 8 | Port write byte |
| lp_rdata | input | 8 | Port read byte, same cycle |
| ex_valid | output | 1 | Extended operation this cycle |
| ex_sel | output | 1 | 0 = index register, 1 = data register |
| ex_we | output | 1 | Extended write |
| ex_wdata | output | 16 | Index value or data halfword |
| ex_rdata | input | 16 | Data register read value, same cycle |

## Verification
Each result falls due at a fixed cycle count. A back-end operation appears one cycle after capture plus its step number. A register model updates on the edge that ends that cycle. `bus_ready` returns max(N,1) cycles after the capture edge, with the read data registered on the same edge.

The bench drives and samples only on falling edges. It counts the falling edges seen with `bus_ready` low and compares that count with N, computed from the size and the region. It reads `bus_rdata` at the first falling edge where `bus_ready` is high again.

Ordering is checked through the result, not by watching the bus. The register models sit behind index registers, so issuing data before its index would leave a wrong value that a later read exposes.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
    localparam int unsigned LBR_ADDR_W = 12;
    localparam int unsigned LBR_DATA_W = 32;
    localparam int unsigned LBR_BYTES  = LBR_DATA_W / 8;
    localparam int unsigned LBR_STEP_W = $clog2(LBR_BYTES + 1);
    localparam int unsigned LBR_SIZE_W = $clog2(LBR_BYTES + 1);
    localparam int unsigned LBR_HALF_W = 16;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_LP   = 2'd1,
        RG_EX   = 2'd2
    } region_e;

    typedef struct packed {
        logic                  busy;
        logic                  we;
        region_e               rg;
        logic [LBR_ADDR_W-1:0] off;
        logic [LBR_DATA_W-1:0] wdata;
        logic [LBR_DATA_W-1:0] rdata;
        logic [LBR_STEP_W-1:0] step;
        logic [LBR_STEP_W-1:0] nsteps;
    } seq_s;
endpackage

// File: rtl/lbr_decode.sv
module lbr_decode
    import lbr_pkg::*;
#(
    parameter int unsigned LP_BASE  = 'h400,
    parameter int unsigned LP_LEN   = 'h20,
    parameter int unsigned EX_BASE  = 'h500,
    parameter int unsigned EX_SLOTS = 11
) (
    input  logic                  win_en,
    input  logic [LBR_ADDR_W-1:0] addr,
    input  logic [LBR_SIZE_W-1:0] size,
    output region_e               rg,
    output logic [LBR_ADDR_W-1:0] off,
    output logic [LBR_STEP_W-1:0] nsteps
);
    localparam int unsigned EX_LEN = 2 * EX_SLOTS;
    localparam logic [LBR_ADDR_W-1:0] LP_LO = LBR_ADDR_W'(LP_BASE);
    localparam logic [LBR_ADDR_W-1:0] LP_HI = LBR_ADDR_W'(LP_BASE + LP_LEN);
    localparam logic [LBR_ADDR_W-1:0] EX_LO = LBR_ADDR_W'(EX_BASE);
    localparam logic [LBR_ADDR_W-1:0] EX_HI = LBR_ADDR_W'(EX_BASE + EX_LEN);
    localparam logic [LBR_SIZE_W-1:0] SZ_MAX = LBR_SIZE_W'(LBR_BYTES);

    logic size_ok;
    logic in_lp;
    logic in_ex;

    always_comb begin
        size_ok = (size != '0) && (size <= SZ_MAX);
        in_lp   = (addr >= LP_LO) && (addr < LP_HI);
        in_ex   = (addr >= EX_LO) && (addr < EX_HI);
        rg      = RG_NONE;
        off     = '0;
        nsteps  = '0;
        if (win_en && size_ok) begin
            if (in_lp) begin
                rg     = RG_LP;
                off    = addr - LP_LO;
                nsteps = LBR_STEP_W'(size);
            end else if (in_ex) begin
                rg     = RG_EX;
                off    = addr - EX_LO;
                // two steps per halfword, odd sizes round up
                nsteps = LBR_STEP_W'(size) + LBR_STEP_W'(size[0]);
            end
        end
    end
endmodule

// File: rtl/lbr_opgen.sv
module lbr_opgen
    import lbr_pkg::*;
#(
    parameter int unsigned LP_LEN       = 'h20,
    parameter int unsigned LP_PORT_BASE = 'h3C0,
    parameter int unsigned PORT_W       = 10,
    parameter int unsigned EX_SLOTS     = 11
) (
    input  logic                  busy,
    input  logic                  we,
    input  region_e               rg,
    input  logic [LBR_ADDR_W-1:0] off,
    input  logic [LBR_DATA_W-1:0] wdata,
    input  logic [LBR_STEP_W-1:0] step,
    output logic                  lp_valid,
    output logic                  lp_we,
    output logic [PORT_W-1:0]     lp_addr,
    output logic [7:0]            lp_wdata,
    output logic                  ex_valid,
    output logic                  ex_sel,
    output logic                  ex_we,
    output logic [LBR_HALF_W-1:0] ex_wdata,
    output logic                  cap_lp,
    output logic                  cap_ex
);
    logic [LBR_ADDR_W-1:0] byte_off;
    logic [LBR_ADDR_W-1:0] slot;
    logic [LBR_STEP_W-1:0] half;
    logic                  phase;
    logic                  lp_in;
    logic                  ex_in;

    always_comb begin
        byte_off = off + LBR_ADDR_W'(step);
        half     = step >> 1;
        slot     = (off >> 1) + LBR_ADDR_W'(half);
        phase    = step[0];
        lp_in    = byte_off < LBR_ADDR_W'(LP_LEN);
        ex_in    = slot < LBR_ADDR_W'(EX_SLOTS);

        lp_valid = busy && (rg == RG_LP) && lp_in;
        lp_we    = we;
        lp_addr  = PORT_W'(LP_PORT_BASE) + PORT_W'(byte_off);
        lp_wdata = wdata[8*step +: 8];

        ex_valid = busy && (rg == RG_EX) && ex_in;
        ex_sel   = phase;
        ex_we    = phase ? we : 1'b1;
        ex_wdata = phase ? wdata[LBR_HALF_W*half +: LBR_HALF_W]
                         : LBR_HALF_W'(slot);

        cap_lp   = lp_valid && !we;
        cap_ex   = ex_valid && phase && !we;
    end
endmodule

// File: rtl/mmio_legacy_bridge.sv
module mmio_legacy_bridge
    import lbr_pkg::*;
#(
    parameter int unsigned LP_BASE      = 'h400,
    parameter int unsigned LP_LEN       = 'h20,
    parameter int unsigned LP_PORT_BASE = 'h3C0,
    parameter int unsigned PORT_W       = 10,
    parameter int unsigned EX_BASE      = 'h500,
    parameter int unsigned EX_SLOTS     = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win_en,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [LBR_ADDR_W-1:0] bus_addr,
    input  logic [LBR_SIZE_W-1:0] bus_size,
    input  logic [LBR_DATA_W-1:0] bus_wdata,
    output logic [LBR_DATA_W-1:0] bus_rdata,
    output logic                  bus_ready,
    output logic                  lp_valid,
    output logic                  lp_we,
    output logic [PORT_W-1:0]     lp_addr,
    output logic [7:0]            lp_wdata,
    input  logic [7:0]            lp_rdata,
    output logic                  ex_valid,
    output logic                  ex_sel,
    output logic                  ex_we,
    output logic [LBR_HALF_W-1:0] ex_wdata,
    input  logic [LBR_HALF_W-1:0] ex_rdata
);
    localparam logic [PORT_W-1:0] PORT_LO = PORT_W'(LP_PORT_BASE);
    localparam logic [PORT_W-1:0] PORT_HI = PORT_W'(LP_PORT_BASE + LP_LEN);

    seq_s                  seq_q;
    seq_s                  seq_d;
    region_e               dec_rg;
    logic [LBR_ADDR_W-1:0] dec_off;
    logic [LBR_STEP_W-1:0] dec_n;
    logic                  cap_lp;
    logic                  cap_ex;
    logic                  last_step;

    lbr_decode #(
        .LP_BASE (LP_BASE),
        .LP_LEN  (LP_LEN),
        .EX_BASE (EX_BASE),
        .EX_SLOTS(EX_SLOTS)
    ) u_decode (
        .win_en(win_en),
        .addr  (bus_addr),
        .size  (bus_size),
        .rg    (dec_rg),
        .off   (dec_off),
        .nsteps(dec_n)
    );

    lbr_opgen #(
        .LP_LEN      (LP_LEN),
        .LP_PORT_BASE(LP_PORT_BASE),
        .PORT_W      (PORT_W),
        .EX_SLOTS    (EX_SLOTS)
    ) u_opgen (
        .busy    (seq_q.busy),
        .we      (seq_q.we),
        .rg      (seq_q.rg),
        .off     (seq_q.off),
        .wdata   (seq_q.wdata),
        .step    (seq_q.step),
        .lp_valid(lp_valid),
        .lp_we   (lp_we),
        .lp_addr (lp_addr),
        .lp_wdata(lp_wdata),
        .ex_valid(ex_valid),
        .ex_sel  (ex_sel),
        .ex_we   (ex_we),
        .ex_wdata(ex_wdata),
        .cap_lp  (cap_lp),
        .cap_ex  (cap_ex)
    );

    always_comb begin
        seq_d     = seq_q;
        last_step = ({1'b0, seq_q.step} + 1'b1) >= {1'b0, seq_q.nsteps};
        if (!seq_q.busy) begin
            if (bus_req) begin
                seq_d.busy   = 1'b1;
                seq_d.we     = bus_we;
                seq_d.rg     = dec_rg;
                seq_d.off    = dec_off;
                seq_d.wdata  = bus_wdata;
                seq_d.rdata  = '0;
                seq_d.step   = '0;
                seq_d.nsteps = dec_n;
            end
        end else begin
            if (cap_lp) begin
                seq_d.rdata[8*seq_q.step +: 8] = lp_rdata;
            end
            if (cap_ex) begin
                seq_d.rdata[LBR_HALF_W*(seq_q.step >> 1) +: LBR_HALF_W] = ex_rdata;
            end
            if (last_step) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.step = seq_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bus_ready = !seq_q.busy;
    assign bus_rdata = seq_q.rdata;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (!lp_valid && !ex_valid)); // R2

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.nsteps != '0) |-> (seq_q.step < seq_q.nsteps)); // R2

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready && !win_en) |=> (!lp_valid && !ex_valid && !bus_ready)); // R10

    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lp_valid |-> (lp_addr >= PORT_LO && lp_addr < PORT_HI)); // R5

    AST_INDEX_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_sel) |=> (ex_valid && ex_sel)); // R6

    AST_DATA_AFTER_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_sel) |-> $past(ex_valid && !ex_sel)); // R6

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_sel) |-> (ex_wdata < LBR_HALF_W'(EX_SLOTS))); // R8
endmodule

// File: tb/tb_mmio_legacy_bridge.sv
module tb_mmio_legacy_bridge;
    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h400, 3'd1, 32'h0000_0011, 32'h0},          // R3 byte write
        '{1'b1, 12'h402, 3'd2, 32'h0000_BBAA, 32'h0},          // R4
        '{1'b0, 12'h400, 3'd4, 32'h0, 32'hBBAA_0011},          // R4 word read
        '{1'b1, 12'h404, 3'd2, 32'h0000_5A03, 32'h0},          // R4 index then data
        '{1'b0, 12'h404, 3'd2, 32'h0, 32'h0000_5A03},          // R4
        '{1'b0, 12'h403, 3'd3, 32'h0, 32'h005A_03BB},          // R4 three bytes
        '{1'b1, 12'h41E, 3'd4, 32'hDDCC_BBAA, 32'h0},          // R5
        '{1'b0, 12'h41E, 3'd4, 32'h0, 32'h0000_BBAA},          // R5
        '{1'b1, 12'h504, 3'd2, 32'h0000_1234, 32'h0},          // R6
        '{1'b1, 12'h506, 3'd4, 32'h89AB_5678, 32'h0},          // R6
        '{1'b0, 12'h504, 3'd4, 32'h0, 32'h5678_1234},          // R6
        '{1'b0, 12'h507, 3'd1, 32'h0, 32'h0000_5678},          // R7
        '{1'b1, 12'h504, 3'd1, 32'h0000_00C1, 32'h0},          // R7 byte write -> halfword
        '{1'b0, 12'h504, 3'd2, 32'h0, 32'h0000_00C1},          // R7
        '{1'b1, 12'h514, 3'd4, 32'hEEEE_7777, 32'h0},          // R8
        '{1'b0, 12'h514, 3'd4, 32'h0, 32'h0000_7777},          // R8
        '{1'b0, 12'h512, 3'd4, 32'h0, 32'h7777_0000},          // R8
        '{1'b1, 12'h300, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R9
        '{1'b0, 12'h300, 3'd4, 32'h0, 32'h0},                  // R9
        '{1'b0, 12'h420, 3'd2, 32'h0, 32'h0},                  // R9
        '{1'b0, 12'h516, 3'd2, 32'h0, 32'h0},                  // R9
        '{1'b0, 12'h400, 3'd0, 32'h0, 32'h0},                  // R11
        '{1'b1, 12'h400, 3'd5, 32'h0000_0099, 32'h0}           // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_en = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        lp_valid, lp_we;
    logic [9:0]  lp_addr;
    logic [7:0]  lp_wdata, lp_rdata;
    logic        ex_valid, ex_sel, ex_we;
    logic [15:0] ex_wdata, ex_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int n_lp = 0;
    int n_ex = 0;

    // back-end register models
    logic [7:0]  plain [32];
    logic [7:0]  seqidx;
    logic [7:0]  seqreg [8];
    logic [3:0]  ex_idx;
    logic [15:0] ex_file [16];

    always #4 clk = ~clk;

    mmio_legacy_bridge dut (
        .clk(clk), .rst_n(rst_n), .win_en(win_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .lp_valid(lp_valid), .lp_we(lp_we), .lp_addr(lp_addr),
        .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
        .ex_valid(ex_valid), .ex_sel(ex_sel), .ex_we(ex_we),
        .ex_wdata(ex_wdata), .ex_rdata(ex_rdata)
    );

    initial begin
        for (int i = 0; i < 32; i++) plain[i] = '0;
        for (int i = 0; i < 8; i++) seqreg[i] = '0;
        for (int i = 0; i < 16; i++) ex_file[i] = '0;
        seqidx = '0;
        ex_idx = '0;
    end

    always_comb begin
        if (lp_addr == 10'h3C4) lp_rdata = seqidx;
        else if (lp_addr == 10'h3C5) lp_rdata = seqreg[seqidx[2:0]];
        else lp_rdata = plain[lp_addr[4:0]];
        ex_rdata = ex_file[ex_idx];
    end

    always @(posedge clk) begin
        if (lp_valid) n_lp <= n_lp + 1;
        if (ex_valid) n_ex <= n_ex + 1;
        if (lp_valid && lp_we) begin
            if (lp_addr == 10'h3C4) seqidx <= lp_wdata;
            else if (lp_addr == 10'h3C5) seqreg[seqidx[2:0]] <= lp_wdata;
            else plain[lp_addr[4:0]] <= lp_wdata;
        end
        if (ex_valid && ex_we) begin
            if (!ex_sel) ex_idx <= ex_wdata[3:0];
            else ex_file[ex_idx] <= ex_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_cycles(input logic en, input logic [11:0] a, input logic [2:0] s);
        if (!en || s == 3'd0 || s > 3'd4) return 1;
        if (a >= 12'h400 && a < 12'h420) return int'(s);
        if (a >= 12'h500 && a < 12'h516) return int'(s) + int'(s[0]);
        return 1;
    endfunction

    task automatic access(input logic we, input logic [11:0] a, input logic [2:0] s,
                          input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = s; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        cyc = 0;
        while (!bus_ready) begin
            cyc++;
            @(negedge clk);
        end
        rd = bus_rdata;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        int lp0;
        int ex0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", {31'b0, bus_ready}, 32'd1);
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 no ops", {30'b0, lp_valid, ex_valid}, 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].we, VECS[v].addr, VECS[v].size, VECS[v].wdata, rd, cyc);
            chk($sformatf("R2 cycles vec%0d", v), 32'(cyc),
                32'(exp_cycles(1'b1, VECS[v].addr, VECS[v].size)));
            chk($sformatf("data vec%0d (see table tag)", v), rd, VECS[v].exp);
        end

        // R11: the size-5 write must not have touched port 0x3C0
        access(1'b0, 12'h400, 3'd1, 32'h0, rd, cyc);
        chk("R11 oversize write ignored", rd, 32'h0000_0011);

        // R5: only two bytes issued at the top edge of the port region
        lp0 = n_lp;
        access(1'b1, 12'h41E, 3'd4, 32'h4433_2211, rd, cyc);
        chk("R5 op count", 32'(n_lp - lp0), 32'd2);

        // R8: slot 11 is never written through the extended data register
        chk("R8 slot11 untouched", {16'h0, ex_file[11]}, 32'h0);

        // R6: four operations for a two-halfword access
        ex0 = n_ex;
        access(1'b0, 12'h504, 3'd4, 32'h0, rd, cyc);
        chk("R6 op count", 32'(n_ex - ex0), 32'd4);

        // R3: a single port-region byte goes to the mapped port
        access(1'b1, 12'h40A, 3'd1, 32'h0000_00E7, rd, cyc);
        chk("R3 port 0x3CA", {24'h0, plain[10]}, 32'h0000_00E7);

        // R10: window disabled
        win_en = 1'b0;
        lp0 = n_lp;
        ex0 = n_ex;
        access(1'b1, 12'h400, 3'd1, 32'h0000_0077, rd, cyc);
        chk("R10 cycles", 32'(cyc), 32'(exp_cycles(1'b0, 12'h400, 3'd1)));
        access(1'b0, 12'h504, 3'd4, 32'h0, rd, cyc);
        chk("R10 read zero", rd, 32'h0);
        chk("R10 no ops", 32'((n_lp - lp0) + (n_ex - ex0)), 32'd0);
        win_en = 1'b1;
        access(1'b0, 12'h400, 3'd1, 32'h0, rd, cyc);
        chk("R10 write ignored", rd, 32'h0000_0011);

        // R2: read data holds while idle
        repeat (3) @(negedge clk);
        chk("R2 rdata held", bus_rdata, 32'h0000_0011);

        finish_run();
    end
endmodule